// File: doc/BRIEF.md
# Hardwired Interrupt Vector Opcode Injector

This block sits in the fetch path of a small 8-bit core, between the memory read data and the opcode register. The core has no external interrupt vector bus. Instead it has seven dedicated request lines, numbered 1 to 7. Line n is bound to the restart target n×8, so the targets run from 0008H to 0038H. Vector 0 has no request line because it is the reset entry.

At each instruction-fetch boundary the core pulses `fetch_i`. If the enable flag is set and at least one request line is high at that edge, the block does three things:
- it enters an interrupt cycle,
- it raises the shared acknowledge,
- it clears the enable flag and records the highest-numbered active line.

When the core next pulses `latch_i`, the block loads a restart opcode `11nnn111` into the opcode register in place of the memory byte, with nnn the recorded line number. In the same edge it ends the interrupt cycle and drops the acknowledge. Outside an interrupt cycle the opcode register takes the data input unchanged.

Software sets and clears the enable flag through two strobes. Software must place its main code at 0040H or above so that the restart slots stay free. Unused request lines are tied low.

Top module: `irq_vector_injector`

## Requirements
- R1: After reset, `ack_o`, `int_cyc_o` and `ie_o` are 0, and `opcode_o` is 8'hC7, the restart to 0000H.
- R2: A `latch_i` edge outside an interrupt cycle loads `data_i` into `opcode_o` unchanged.
- R3: A `fetch_i` edge with `ie_o`=1 and any `irq_i` bit set raises both `int_cyc_o` and `ack_o` after that edge.
- R4: A `fetch_i` edge with `ie_o`=0 starts no interrupt cycle, whatever the request lines are.
- R5: A `fetch_i` edge with `ie_o`=1 and no request line high starts no interrupt cycle and leaves `ie_o` at 1.
- R6: A `latch_i` edge during an interrupt cycle loads `{2'b11, n[2:0], 3'b111}`, with n the winning line. This is the restart to address n×8, and `data_i` is ignored.
- R7: When several request lines are high at the fetch edge, the highest-numbered line is the winner.
- R8: The `latch_i` edge that loads the forced opcode clears `int_cyc_o` and `ack_o` in that same edge.
- R9: Accepting an interrupt clears `ie_o`. A further fetch with requests still high starts no cycle until `ie_o` is set again.
- R10: Request lines are sampled only at the fetch edge. A request that falls before the fetch edge is ignored. A change of the lines after the accepting fetch edge does not change the forced opcode.
- R11: `ie_set_i` sets `ie_o` and `ie_clr_i` clears it; when both are high, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_i | input | 1 | Instruction-fetch boundary strobe |
| latch_i | input | 1 | Opcode register load strobe |
| ie_set_i | input | 1 | Set interrupt enable |
| ie_clr_i | input | 1 | Clear interrupt enable |
| irq_i | input | 7 | Request lines, bit n is line n (bits 7:1) |
| data_i | input | 8 | Fetched memory byte |
| opcode_o | output | 8 | Opcode register |
| ack_o | output | 1 | Shared interrupt acknowledge |
| int_cyc_o | output | 1 | Interrupt cycle in progress |
| ie_o | output | 1 | Interrupt enable flag |

## Verification
All results are registered and appear exactly one clock edge after their strobe:
- `int_cyc_o`, `ack_o` and `ie_o` settle after the `fetch_i` edge that accepts the interrupt;
- `opcode_o` and the cleared cycle flag settle after the `latch_i` edge;
- the enable flag moves one edge after `ie_set_i` or `ie_clr_i`.

The bench drives its strobes for one cycle from the falling edge and samples 1 ns after the following rising edge, so every check reads the value due after that single edge. Request lines are changed between the fetch edge and the latch edge to show that only the fetch edge samples them.

// File: rtl/irqinj_pkg.sv
package irqinj_pkg;
  localparam int unsigned OPC_W = 8;
  localparam int unsigned IDX_W = 3;
  localparam int unsigned NUM_REQ = (1 << IDX_W) - 1;
  localparam logic [1:0] RST_HI = 2'b11;
  localparam logic [2:0] RST_LO = 3'b111;
  localparam logic [OPC_W-1:0] RESET_OPCODE = {RST_HI, {IDX_W{1'b0}}, RST_LO};

  typedef logic [IDX_W-1:0] line_idx_t;
endpackage

// File: rtl/irqinj_prio_enc.sv
module irqinj_prio_enc #(
  parameter int unsigned NUM_REQ = irqinj_pkg::NUM_REQ,
  parameter int unsigned IDX_W   = irqinj_pkg::IDX_W
) (
  input  logic [NUM_REQ:1]  req_i,
  output logic              any_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [IDX_W-1:0] stage [NUM_REQ+1];

  assign stage[0] = '0;

  // later stages override earlier ones: highest line wins
  for (genvar g = 1; g <= NUM_REQ; g++) begin : g_stage
    localparam logic [IDX_W-1:0] LINE = IDX_W'(g);
    assign stage[g] = req_i[g] ? LINE : stage[g-1];
  end

  assign idx_o = stage[NUM_REQ];
  assign any_o = |req_i;
endmodule

// File: rtl/irqinj_opcode_gen.sv
module irqinj_opcode_gen
  import irqinj_pkg::*;
#(
  parameter int unsigned LIDX_W = IDX_W
) (
  input  logic [LIDX_W-1:0] idx_i,
  output logic [OPC_W-1:0]  opcode_o
);
  localparam int unsigned PAD_W = OPC_W - LIDX_W - 5;

  if (PAD_W == 0) begin : g_exact
    assign opcode_o = {RST_HI, idx_i, RST_LO};
  end else begin : g_pad
    assign opcode_o = {RST_HI, {PAD_W{1'b0}}, idx_i, RST_LO};
  end
endmodule

// File: rtl/irqinj_ctrl.sv
module irqinj_ctrl #(
  parameter int unsigned IDX_W = irqinj_pkg::IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fetch_i,
  input  logic             latch_i,
  input  logic             ie_set_i,
  input  logic             ie_clr_i,
  input  logic             any_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             ie_o,
  output logic             cyc_o,
  output logic             ack_o,
  output logic [IDX_W-1:0] win_o
);
  logic             ie_q, cyc_q, ack_q;
  logic [IDX_W-1:0] win_q;
  logic             accept;

  assign accept = fetch_i & ie_q & any_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      cyc_q <= 1'b0;
      ack_q <= 1'b0;
      win_q <= '0;
    end else if (accept) begin
      cyc_q <= 1'b1;
      ack_q <= 1'b1;
      ie_q  <= 1'b0;
      win_q <= idx_i;  // freeze winner at fetch boundary
    end else begin
      if (latch_i) begin
        cyc_q <= 1'b0;
        ack_q <= 1'b0;
      end
      if (ie_clr_i)      ie_q <= 1'b0;
      else if (ie_set_i) ie_q <= 1'b1;
    end
  end

  assign ie_o  = ie_q;
  assign cyc_o = cyc_q;
  assign ack_o = ack_q;
  assign win_o = win_q;
endmodule

// File: rtl/irqinj_opcode_reg.sv
module irqinj_opcode_reg
  import irqinj_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             latch_i,
  input  logic             force_i,
  input  logic [OPC_W-1:0] forced_i,
  input  logic [OPC_W-1:0] data_i,
  output logic [OPC_W-1:0] opcode_o
);
  logic [OPC_W-1:0] opc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      opc_q <= RESET_OPCODE;
    else if (latch_i) opc_q <= force_i ? forced_i : data_i;
  end

  assign opcode_o = opc_q;
endmodule

// File: rtl/irq_vector_injector.sv
module irq_vector_injector
  import irqinj_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_i,
  input  logic               latch_i,
  input  logic               ie_set_i,
  input  logic               ie_clr_i,
  input  logic [NUM_REQ:1]   irq_i,
  input  logic [OPC_W-1:0]   data_i,
  output logic [OPC_W-1:0]   opcode_o,
  output logic               ack_o,
  output logic               int_cyc_o,
  output logic               ie_o
);
  logic             any_req;
  logic [IDX_W-1:0] top_idx, win_idx;
  logic [OPC_W-1:0] rst_opc;
  logic             cyc;

  irqinj_prio_enc #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_prio (
    .req_i (irq_i),
    .any_o (any_req),
    .idx_o (top_idx)
  );

  irqinj_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fetch_i  (fetch_i),
    .latch_i  (latch_i),
    .ie_set_i (ie_set_i),
    .ie_clr_i (ie_clr_i),
    .any_i    (any_req),
    .idx_i    (top_idx),
    .ie_o     (ie_o),
    .cyc_o    (cyc),
    .ack_o    (ack_o),
    .win_o    (win_idx)
  );

  irqinj_opcode_gen #(.LIDX_W(IDX_W)) u_gen (
    .idx_i    (win_idx),
    .opcode_o (rst_opc)
  );

  irqinj_opcode_reg u_opc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .latch_i  (latch_i),
    .force_i  (cyc),
    .forced_i (rst_opc),
    .data_i   (data_i),
    .opcode_o (opcode_o)
  );

  assign int_cyc_o = cyc;
endmodule

// File: rtl/irqinj_chk.sv
module irqinj_chk
  import irqinj_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fetch_i,
  input logic             latch_i,
  input logic             ie_set_i,
  input logic             ie_clr_i,
  input logic [NUM_REQ:1] irq_i,
  input logic [OPC_W-1:0] data_i,
  input logic [OPC_W-1:0] opcode_o,
  input logic             ack_o,
  input logic             int_cyc_o,
  input logic             ie_o
);
  p_enter_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && ie_o && (|irq_i)) |=> (int_cyc_o && ack_o));

  p_rise_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_cyc_o) |-> $past(fetch_i && ie_o && (|irq_i)));

  p_no_req_keeps_ie_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && ie_o && !(|irq_i) && !ie_clr_i) |=> ie_o);

  p_normal_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && !int_cyc_o) |=> (opcode_o == $past(data_i)));

  p_forced_form_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && int_cyc_o) |=> (opcode_o[7:6] == 2'b11 && opcode_o[2:0] == 3'b111
                                && opcode_o[5:3] != 3'b000));

  p_latch_ends_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && int_cyc_o && !fetch_i) |=> (!int_cyc_o && !ack_o));

  p_accept_clears_ie_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && ie_o && (|irq_i)) |=> !ie_o);

  p_ie_clr_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_clr_i |=> !ie_o);

  p_ack_with_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o == int_cyc_o);

  p_opcode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(opcode_o));
endmodule

bind irq_vector_injector irqinj_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fetch_i   (fetch_i),
  .latch_i   (latch_i),
  .ie_set_i  (ie_set_i),
  .ie_clr_i  (ie_clr_i),
  .irq_i     (irq_i),
  .data_i    (data_i),
  .opcode_o  (opcode_o),
  .ack_o     (ack_o),
  .int_cyc_o (int_cyc_o),
  .ie_o      (ie_o)
);

// File: tb/tb_irq_vector_injector.sv
`timescale 1ns / 1ps
module tb_irq_vector_injector;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fetch_i = 1'b0, latch_i = 1'b0, ie_set_i = 1'b0, ie_clr_i = 1'b0;
  logic [7:1] irq_i = '0;
  logic [7:0] data_i = '0;
  logic [7:0] opcode_o;
  logic       ack_o, int_cyc_o, ie_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  irq_vector_injector dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fetch_i(fetch_i), .latch_i(latch_i),
    .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i), .irq_i(irq_i), .data_i(data_i),
    .opcode_o(opcode_o), .ack_o(ack_o), .int_cyc_o(int_cyc_o), .ie_o(ie_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one cycle of strobes, driven at negedge, sampled 1 ns after posedge
  task automatic step(input bit f, input bit l, input bit s, input bit c);
    @(negedge clk_i);
    fetch_i = f; latch_i = l; ie_set_i = s; ie_clr_i = c;
    @(posedge clk_i);
    #1;
    fetch_i = 0; latch_i = 0; ie_set_i = 0; ie_clr_i = 0;
  endtask

  function automatic logic [7:0] rst_code(input int n);
    return 8'(8'hC7 | (n << 3));
  endfunction

  task automatic t_reset();
    chk("R1 opcode", opcode_o, 8'hC7);
    chk("R1 ack", {7'd0, ack_o}, 8'd0);
    chk("R1 cyc", {7'd0, int_cyc_o}, 8'd0);
    chk("R1 ie", {7'd0, ie_o}, 8'd0);
  endtask

  task automatic t_normal();
    data_i = 8'h3A;
    step(0, 1, 0, 0);
    chk("R2 load", opcode_o, 8'h3A);
    irq_i = 7'h7F;
    step(1, 0, 0, 0);
    chk("R4 no cycle", {7'd0, int_cyc_o}, 8'd0);
    chk("R4 no ack", {7'd0, ack_o}, 8'd0);
    data_i = 8'hA5;
    step(0, 1, 0, 0);
    chk("R4 data kept", opcode_o, 8'hA5);
    irq_i = '0;
  endtask

  task automatic t_enable();
    step(0, 0, 1, 0);
    chk("R11 set", {7'd0, ie_o}, 8'd1);
    step(0, 0, 0, 1);
    chk("R11 clr", {7'd0, ie_o}, 8'd0);
    step(0, 0, 1, 0);
    step(0, 0, 1, 1);
    chk("R11 clr wins", {7'd0, ie_o}, 8'd0);
  endtask

  task automatic t_no_req();
    step(0, 0, 1, 0);
    irq_i = '0;
    step(1, 0, 0, 0);
    chk("R5 no cycle", {7'd0, int_cyc_o}, 8'd0);
    chk("R5 ie kept", {7'd0, ie_o}, 8'd1);
    step(0, 0, 0, 1);
  endtask

  task automatic t_single();
    for (int n = 1; n <= 7; n++) begin
      step(0, 0, 1, 0);
      irq_i = '0; irq_i[n] = 1'b1;
      step(1, 0, 0, 0);
      chk("R3 cycle", {7'd0, int_cyc_o}, 8'd1);
      chk("R3 ack", {7'd0, ack_o}, 8'd1);
      chk("R9 ie cleared", {7'd0, ie_o}, 8'd0);
      irq_i = '0;
      data_i = 8'h00;
      step(0, 1, 0, 0);
      chk("R6 restart opcode", opcode_o, rst_code(n));
      chk("R8 cycle end", {7'd0, int_cyc_o}, 8'd0);
      chk("R8 ack end", {7'd0, ack_o}, 8'd0);
    end
  endtask

  task automatic t_prio();
    step(0, 0, 1, 0);
    irq_i = 7'b0010110;  // lines 2,3,5
    step(1, 0, 0, 0);
    irq_i = '0;
    step(0, 1, 0, 0);
    chk("R7 highest of 2,3,5", opcode_o, 8'hEF);
    step(0, 0, 1, 0);
    irq_i = 7'h7F;
    step(1, 0, 0, 0);
    irq_i = '0;
    step(0, 1, 0, 0);
    chk("R7 all lines", opcode_o, 8'hFF);
  endtask

  task automatic t_back_to_back();
    step(0, 0, 1, 0);
    irq_i = '0; irq_i[4] = 1'b1;
    step(1, 0, 0, 0);
    step(0, 1, 0, 0);
    chk("R9 first taken", opcode_o, 8'hE7);
    data_i = 8'h12;
    step(1, 0, 0, 0);
    chk("R9 no re-entry", {7'd0, int_cyc_o}, 8'd0);
    step(0, 1, 0, 0);
    chk("R9 data after", opcode_o, 8'h12);
    step(0, 0, 1, 0);
    step(1, 0, 0, 0);
    chk("R9 re-enabled", {7'd0, int_cyc_o}, 8'd1);
    step(0, 1, 0, 0);
    irq_i = '0;
  endtask

  task automatic t_sampling();
    step(0, 0, 1, 0);
    @(negedge clk_i); irq_i[6] = 1'b1;
    @(negedge clk_i); irq_i = '0;
    step(1, 0, 0, 0);
    chk("R10 dropped request", {7'd0, int_cyc_o}, 8'd0);
    irq_i[2] = 1'b1;
    step(1, 0, 0, 0);
    irq_i = '0; irq_i[7] = 1'b1;  // change after fetch edge
    data_i = 8'h55;
    step(0, 1, 0, 0);
    chk("R10 winner frozen", opcode_o, 8'hD7);
    irq_i = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_normal();
    t_enable();
    t_no_req();
    t_single();
    t_prio();
    t_back_to_back();
    t_sampling();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule